// File: doc/BRIEF.md
# Serial Configuration Memory Loader

This block is the only master on a two-wire serial bus wired point to point to a configuration EEPROM. Once reset is released it waits a programmable number of system clocks and then fetches a block of 16-bit configuration words on its own, starting at word address zero. After the whole block has arrived without a missing acknowledge, it raises `loaded`. That output stays high until the next reset. If the memory fails to acknowledge, the load is abandoned with a STOP, `cfgFail` is set, and the load is tried again after the same delay.

Once loaded, the block also takes host commands. A read command returns two consecutive words and a write command stores one word. A strap input picks the addressing format. Small devices carry address bits 10..8 inside the device-select byte and send one address byte. Large devices use a fixed device-select byte and send two address bytes. Both bus lines are open drain: the block only pulls them low or lets go. Another master may use the bus only while this block is held in reset.

Top module: `prom_cfg_loader`

## Requirements
- R1: While `rstN` is low, `loaded`, `cfgFail`, `cmdReady`, `cmdDone`, `sclLow` and `sdaLow` are all 0.
- R2: No bus activity occurs earlier than START_DELAY clocks after reset release. The first pull on SCL comes no later than START_DELAY+QUARTER_CYCLES+4 clocks after release.
- R3: The startup load reads CFG_WORDS words from byte address 0. Each word is built low byte first, and word k lands in `cfgData[16k+15:16k]`. `loaded` then rises and stays high until reset.
- R4: When `sizeLarge`=0, the byte address is twice the word address. The write select byte is {1010, byteAddr[10:8], 0}. It is followed by one address byte, byteAddr[7:0].
- R5: When `sizeLarge`=1, the write select byte is 8'hA0. It is followed by byteAddr[15:8] and then byteAddr[7:0].
- R6: A host read (`cmdWrite`=0) returns the word at `cmdAddr` in `rdData[15:0]` and the next word in `rdData[31:16]`. Completion is signalled by a one-cycle `cmdDone` with `cmdErr`=0.
- R7: A host write (`cmdWrite`=1) stores `cmdWdata[7:0]` at the even byte address and `cmdWdata[15:8]` at the next byte address.
- R8: A read sends a repeated START and then select byte {1010, a[10:8] or 000, 1}. The master acknowledges every data byte except the last, answers the last with NACK, and ends with STOP.
- R9: When the memory gives no acknowledge, the transfer ends with a STOP. A host command completes with `cmdErr`=1. A startup load sets `cfgFail`, keeps `loaded` low and retries after the start delay.
- R10: Each SCL low phase and each SCL high phase lasts at least 2*QUARTER_CYCLES clocks. SCL changes level only on a quarter-period tick.
- R11: `cmdReady` is high only when `loaded` is high and no transfer is running. A command held before the load completes is served only after the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sizeLarge | input | 1 | Device size strap: 0 = small (one address byte), 1 = large (two address bytes) |
| cmdValid | input | 1 | Host command request |
| cmdWrite | input | 1 | 1 = write one word, 0 = read two words |
| cmdAddr | input | 15 | Word address of the command |
| cmdWdata | input | 16 | Word to be written |
| cmdReady | output | 1 | Command accepted in a cycle where cmdValid and cmdReady are both high |
| cmdDone | output | 1 | One-cycle pulse when a host command finishes |
| cmdErr | output | 1 | Valid with cmdDone: the memory failed to acknowledge |
| rdData | output | 32 | Two words from the last host read |
| loaded | output | 1 | Configuration block fetched without error |
| cfgFail | output | 1 | Last startup load attempt was not acknowledged |
| cfgData | output | CFG_WORDS*16 | Configuration words, word 0 in the low bits |
| sclLow | output | 1 | Pull the clock line low when 1, release when 0 |
| sdaLow | output | 1 | Pull the data line low when 1, release when 0 |
| sdaIn | input | 1 | Sensed level of the data line |

## Verification
The automatic startup load and a host command can both be pending in the same cycle, when the start delay expires while a host request is already waiting. The bench provokes this by holding `cmdValid` high from the moment reset is released. It then judges that `cmdReady` never rose before `loaded`, and that exactly two bus transactions (load, then read) completed by the time `cmdDone` appeared. It also checks that both the configuration words and the read result are correct.

// File: rtl/prom_ldr_pkg.sv
package prom_ldr_pkg;

  localparam int PROM_BYTE_AW = 16;
  localparam int HOST_WORDS   = 2;

  typedef enum logic [1:0] {OP_START, OP_STOP, OP_WRITE, OP_READ} busOp_e;

  typedef enum logic [1:0] {JOB_CFG, JOB_RD, JOB_WR} job_e;

  typedef enum logic [3:0] {
    ST_DELAY, ST_IDLE, ST_START, ST_DEVW, ST_ADRH, ST_ADRL,
    ST_WDAT, ST_RSTA, ST_DEVR, ST_RDAT, ST_STOP
  } seqState_e;

  typedef struct packed {
    logic       go;
    busOp_e     op;
    logic [7:0] txByte;
    logic       nackLast;
  } busCmd_t;

  typedef struct packed {
    logic       busy;
    logic       done;
    logic [7:0] rxByte;
    logic       ackSeen;
  } busRsp_t;

endpackage

// File: rtl/prom_bus_engine.sv
module prom_bus_engine
  import prom_ldr_pkg::*;
#(
  parameter int QUARTER_CYCLES = 168
) (
  input  logic    clk,
  input  logic    rstN,
  input  busCmd_t cmd,
  output busRsp_t rsp,
  input  logic    sdaIn,
  output logic    sclLow,
  output logic    sdaLow
);

  localparam int DIV_W = $clog2(QUARTER_CYCLES + 1);

  logic             busy, done, tick, bitOp, sclNext, sdaNext;
  busOp_e           opReg;
  logic [1:0]       q;
  logic [3:0]       bitIdx;
  logic [8:0]       shTx, shRx;
  logic [DIV_W-1:0] divCnt;

  assign bitOp = (opReg == OP_WRITE) || (opReg == OP_READ);
  assign tick  = busy && (divCnt == DIV_W'(QUARTER_CYCLES - 1));

  // every op spans four quarters; SCL is low in q0,q1 and released in q2,q3
  always_comb begin
    sclNext = (q < 2'd2);
    sdaNext = sdaLow;
    case (opReg)
      OP_START: begin
        if (q == 2'd1 || q == 2'd2) sdaNext = 1'b0;
        else if (q == 2'd3)         sdaNext = 1'b1;
      end
      OP_STOP: begin
        if (q == 2'd1 || q == 2'd2) sdaNext = 1'b1;
        else if (q == 2'd3)         sdaNext = 1'b0;
      end
      default: if (q != 2'd0) sdaNext = !shTx[8];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; done <= 1'b0; opReg <= OP_START; q <= '0; bitIdx <= '0;
      shTx <= '1; shRx <= '1; divCnt <= '0; sclLow <= 1'b0; sdaLow <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        divCnt <= '0;
        if (cmd.go) begin
          busy   <= 1'b1;
          opReg  <= cmd.op;
          q      <= '0;
          bitIdx <= '0;
          shTx   <= (cmd.op == OP_WRITE) ? {cmd.txByte, 1'b1} : {8'hFF, cmd.nackLast};
        end
      end else if (tick) begin
        divCnt <= '0;
        sclLow <= sclNext;
        sdaLow <= sdaNext;
        if (bitOp && q == 2'd3) shRx <= {shRx[7:0], sdaIn};
        q <= q + 2'd1;
        if (q == 2'd3) begin
          if (!bitOp || bitIdx == 4'd8) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bitIdx <= bitIdx + 4'd1;
            shTx   <= {shTx[7:0], 1'b1};
          end
        end
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end

  assign rsp.busy    = busy;
  assign rsp.done    = done;
  assign rsp.rxByte  = shRx[8:1];
  assign rsp.ackSeen = !shRx[0];

  a_r10_scl_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (sclLow != $past(sclLow)) |-> $past(tick));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/prom_seq_ctrl.sv
module prom_seq_ctrl
  import prom_ldr_pkg::*;
#(
  parameter int START_DELAY = 6000,
  parameter int CFG_WORDS   = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sizeLarge,
  input  logic                      cmdValid,
  input  logic                      cmdWrite,
  input  logic [PROM_BYTE_AW-2:0]   cmdAddr,
  input  logic [15:0]               cmdWdata,
  output logic                      cmdReady,
  output logic                      cmdDone,
  output logic                      cmdErr,
  output logic [HOST_WORDS*16-1:0]  rdData,
  output logic                      loaded,
  output logic                      cfgFail,
  output logic [CFG_WORDS*16-1:0]   cfgData,
  output busCmd_t                   cmd,
  input  busRsp_t                   rsp
);

  localparam int DLY_W = $clog2(START_DELAY + 1);
  localparam int CNT_W = $clog2(2 * CFG_WORDS + 1);

  seqState_e             state;
  job_e                  job;
  logic                  issued, failed, largeReg;
  logic [DLY_W-1:0]      dlyCnt;
  logic [PROM_BYTE_AW-1:0] addrByte;
  logic [15:0]           wdata;
  logic [CNT_W-1:0]      byteCnt, nBytes;
  logic [7:0]            devSel;

  assign devSel   = largeReg ? 8'hA0 : {4'b1010, addrByte[10:8], 1'b0};
  assign cmdReady = loaded && (state == ST_IDLE);

  always_comb begin
    cmd          = '0;
    cmd.nackLast = (byteCnt == nBytes - CNT_W'(1));
    case (state)
      ST_START, ST_RSTA: cmd.op = OP_START;
      ST_STOP:           cmd.op = OP_STOP;
      ST_RDAT:           cmd.op = OP_READ;
      default:           cmd.op = OP_WRITE;
    endcase
    case (state)
      ST_DEVW: cmd.txByte = devSel;
      ST_DEVR: cmd.txByte = devSel | 8'h01;
      ST_ADRH: cmd.txByte = addrByte[15:8];
      ST_ADRL: cmd.txByte = addrByte[7:0];
      ST_WDAT: cmd.txByte = byteCnt[0] ? wdata[15:8] : wdata[7:0];
      default: cmd.txByte = 8'h00;
    endcase
    cmd.go = (state != ST_DELAY) && (state != ST_IDLE) && !issued && !rsp.busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_DELAY; job <= JOB_CFG; issued <= 1'b0; failed <= 1'b0;
      largeReg <= 1'b0; dlyCnt <= '0; addrByte <= '0; wdata <= '0;
      byteCnt <= '0; nBytes <= '0; cmdDone <= 1'b0; cmdErr <= 1'b0;
      rdData <= '0; loaded <= 1'b0; cfgFail <= 1'b0; cfgData <= '0;
    end else begin
      cmdDone <= 1'b0;
      if (cmd.go) issued <= 1'b1;
      if (rsp.done) issued <= 1'b0;
      case (state)
        ST_DELAY: begin
          if (dlyCnt == DLY_W'(START_DELAY - 1)) begin
            dlyCnt <= '0; job <= JOB_CFG; addrByte <= '0; failed <= 1'b0;
            byteCnt <= '0; nBytes <= CNT_W'(2 * CFG_WORDS);
            largeReg <= sizeLarge; state <= ST_START;
          end else dlyCnt <= dlyCnt + DLY_W'(1);
        end
        ST_IDLE: if (cmdValid && cmdReady) begin
          job <= cmdWrite ? JOB_WR : JOB_RD;
          addrByte <= {cmdAddr, 1'b0}; wdata <= cmdWdata; failed <= 1'b0;
          byteCnt <= '0; nBytes <= CNT_W'(2 * HOST_WORDS);
          largeReg <= sizeLarge; state <= ST_START;
        end
        default: if (rsp.done) begin
          case (state)
            ST_START: state <= ST_DEVW;
            ST_RSTA:  state <= ST_DEVR;
            ST_DEVW:  state <= !rsp.ackSeen ? ST_STOP : (largeReg ? ST_ADRH : ST_ADRL);
            ST_ADRH:  state <= rsp.ackSeen ? ST_ADRL : ST_STOP;
            ST_ADRL:  state <= !rsp.ackSeen ? ST_STOP : ((job == JOB_WR) ? ST_WDAT : ST_RSTA);
            ST_WDAT: begin
              if (!rsp.ackSeen || byteCnt[0]) state <= ST_STOP;
              else byteCnt <= byteCnt + CNT_W'(1);
            end
            ST_DEVR: begin
              byteCnt <= '0;
              state   <= rsp.ackSeen ? ST_RDAT : ST_STOP;
            end
            ST_RDAT: begin
              if (job == JOB_CFG) cfgData[{byteCnt, 3'b000} +: 8] <= rsp.rxByte;
              else rdData[{byteCnt[1:0], 3'b000} +: 8] <= rsp.rxByte;
              if (byteCnt == nBytes - CNT_W'(1)) state <= ST_STOP;
              else byteCnt <= byteCnt + CNT_W'(1);
            end
            ST_STOP: begin
              if (job == JOB_CFG) begin
                if (failed) begin cfgFail <= 1'b1; state <= ST_DELAY; end
                else begin cfgFail <= 1'b0; loaded <= 1'b1; state <= ST_IDLE; end
              end else begin
                cmdDone <= 1'b1; cmdErr <= failed; state <= ST_IDLE;
              end
            end
            default: state <= ST_IDLE;
          endcase
          if (!rsp.ackSeen && (state == ST_DEVW || state == ST_ADRH ||
              state == ST_ADRL || state == ST_WDAT || state == ST_DEVR))
            failed <= 1'b1;
        end
      endcase
    end
  end

  a_r11_ready_needs_loaded: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> loaded);

  a_r9_fail_not_loaded: assert property (@(posedge clk) disable iff (!rstN)
    cfgFail |-> !loaded);

  a_r3_loaded_holds: assert property (@(posedge clk) disable iff (!rstN)
    loaded |=> loaded);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |=> !cmdDone);

  a_r11_no_go_in_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !rsp.busy);

endmodule

// File: rtl/prom_cfg_loader.sv
module prom_cfg_loader
  import prom_ldr_pkg::*;
#(
  parameter int QUARTER_CYCLES = 168,
  parameter int START_DELAY    = 6000,
  parameter int CFG_WORDS      = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sizeLarge,
  input  logic                     cmdValid,
  input  logic                     cmdWrite,
  input  logic [PROM_BYTE_AW-2:0]  cmdAddr,
  input  logic [15:0]              cmdWdata,
  output logic                     cmdReady,
  output logic                     cmdDone,
  output logic                     cmdErr,
  output logic [HOST_WORDS*16-1:0] rdData,
  output logic                     loaded,
  output logic                     cfgFail,
  output logic [CFG_WORDS*16-1:0]  cfgData,
  output logic                     sclLow,
  output logic                     sdaLow,
  input  logic                     sdaIn
);

  busCmd_t busCmd;
  busRsp_t busRsp;

  prom_seq_ctrl #(.START_DELAY(START_DELAY), .CFG_WORDS(CFG_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .sizeLarge(sizeLarge), .cmdValid(cmdValid),
    .cmdWrite(cmdWrite), .cmdAddr(cmdAddr), .cmdWdata(cmdWdata),
    .cmdReady(cmdReady), .cmdDone(cmdDone), .cmdErr(cmdErr), .rdData(rdData),
    .loaded(loaded), .cfgFail(cfgFail), .cfgData(cfgData),
    .cmd(busCmd), .rsp(busRsp)
  );

  prom_bus_engine #(.QUARTER_CYCLES(QUARTER_CYCLES)) u_bus (
    .clk(clk), .rstN(rstN), .cmd(busCmd), .rsp(busRsp),
    .sdaIn(sdaIn), .sclLow(sclLow), .sdaLow(sdaLow)
  );

endmodule

// File: tb/prom_cfg_loader_tb.sv
module prom_cfg_loader_tb;

  localparam int CLK_PERIOD = 10;
  localparam int QC = 4;
  localparam int DLY = 40;
  localparam int NW = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic sizeLarge = 1'b0, cmdValid = 1'b0, cmdWrite = 1'b0;
  logic [14:0] cmdAddr = '0;
  logic [15:0] cmdWdata = '0;
  logic cmdReady, cmdDone, cmdErr, loaded, cfgFail, sclLow, sdaLow, sdaIn;
  logic [31:0] rdData;
  logic [NW*16-1:0] cfgData;

  int total = 0, bad = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prom_cfg_loader #(.QUARTER_CYCLES(QC), .START_DELAY(DLY), .CFG_WORDS(NW)) u_dut (
    .clk(clk), .rstN(rstN), .sizeLarge(sizeLarge), .cmdValid(cmdValid),
    .cmdWrite(cmdWrite), .cmdAddr(cmdAddr), .cmdWdata(cmdWdata),
    .cmdReady(cmdReady), .cmdDone(cmdDone), .cmdErr(cmdErr), .rdData(rdData),
    .loaded(loaded), .cfgFail(cfgFail), .cfgData(cfgData),
    .sclLow(sclLow), .sdaLow(sdaLow), .sdaIn(sdaIn)
  );

  // ---------------- memory model on the open-drain bus ----------------
  logic devAbsent = 1'b0, slvLow = 1'b0;
  logic sclBus, sdaBus;
  assign sclBus = !sclLow;
  assign sdaBus = !(sdaLow || slvLow);
  assign sdaIn  = sdaBus;

  logic [7:0] mem [0:2047];
  logic [7:0] rxLog [0:7];
  logic [7:0] sh = '0, txb = '0;
  logic [3:0] bc = '0;
  logic [2:0] st = '0, devHi = '0, rxCnt = '0, lastRxCnt = '0;
  logic [15:0] ptr = '0;
  logic pScl = 1'b1, pSda = 1'b1, rxMode = 1'b1, goTx = 1'b0, mAck = 1'b0, nackSeen = 1'b0;
  int txCnt = 0, lastTx = 0, stops = 0;

  always @(posedge clk) begin
    pScl <= sclBus; pSda <= sdaBus;
    if (pScl && sclBus && pSda && !sdaBus) begin
      bc <= '0; rxMode <= 1'b1; slvLow <= 1'b0; st <= '0; goTx <= 1'b0;
    end else if (pScl && sclBus && !pSda && sdaBus) begin
      slvLow <= 1'b0; rxMode <= 1'b1; st <= '0; bc <= '0;
      lastRxCnt <= rxCnt; rxCnt <= '0; lastTx <= txCnt; txCnt <= 0; stops <= stops + 1;
    end else if (!pScl && sclBus) begin
      if (rxMode && bc < 8) sh <= {sh[6:0], sdaBus};
      if (!rxMode && bc == 8) mAck <= !sdaBus;
      bc <= bc + 4'd1;
    end else if (pScl && !sclBus) begin
      if (rxMode) begin
        if (bc == 8) begin
          rxLog[rxCnt] <= sh; rxCnt <= rxCnt + 3'd1;
          slvLow <= !devAbsent;
          if (!devAbsent) begin
            case (st)
              3'd0: if (sh[0]) goTx <= 1'b1;
                    else begin devHi <= sh[3:1]; st <= sizeLarge ? 3'd1 : 3'd2; end
              3'd1: begin ptr[15:8] <= sh; st <= 3'd2; end
              3'd2: begin ptr <= sizeLarge ? {ptr[15:8], sh} : {5'd0, devHi, sh}; st <= 3'd3; end
              3'd3: begin mem[ptr[10:0]] <= sh; ptr <= ptr + 16'd1; end
              default: ;
            endcase
          end
        end else if (bc == 9) begin
          bc <= '0; slvLow <= 1'b0;
          if (goTx) begin
            goTx <= 1'b0; rxMode <= 1'b0; nackSeen <= 1'b0;
            txb <= mem[ptr[10:0]]; slvLow <= !mem[ptr[10:0]][7];
            ptr <= ptr + 16'd1; txCnt <= txCnt + 1;
          end
        end
      end else begin
        if (bc >= 1 && bc <= 7) slvLow <= !txb[3'(4'd7 - bc)];
        else if (bc == 8) slvLow <= 1'b0;
        else if (bc == 9) begin
          bc <= '0;
          if (mAck) begin
            txb <= mem[ptr[10:0]]; slvLow <= !mem[ptr[10:0]][7];
            ptr <= ptr + 16'd1; txCnt <= txCnt + 1;
          end else begin
            slvLow <= 1'b0; rxMode <= 1'b1; st <= 3'd4; nackSeen <= 1'b1;
          end
        end
      end
    end
  end

  // ---------------- SCL phase monitor and ready monitor ----------------
  int runLen = 0, minLow = 1 << 20, minHigh = 1 << 20;
  logic monOn = 1'b0, prevSclLow = 1'b0, readyEarly = 1'b0;
  always @(posedge clk) begin
    prevSclLow <= sclLow;
    if (sclLow != prevSclLow) begin
      if (monOn && runLen > 0) begin
        if (prevSclLow && runLen < minLow) minLow <= runLen;
        if (!prevSclLow && runLen < minHigh) minHigh <= runLen;
      end
      runLen <= 1;
    end else runLen <= runLen + 1;
    if (rstN && cmdReady && !loaded) readyEarly <= 1'b1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] memWord(input int b);
    return {mem[(b + 1) % 2048], mem[b % 2048]};
  endfunction

  task automatic apply_reset();
    rstN = 1'b0; cmdValid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 loaded", 128'(loaded), 0);
    chk("R1 outs", 128'({cfgFail, cmdReady, cmdDone, sclLow, sdaLow}), 0);
    rstN = 1'b1;
  endtask

  task automatic wait_loaded();
    while (!loaded) @(negedge clk);
  endtask

  task automatic host_cmd(input logic wr, input logic [14:0] a, input logic [15:0] d);
    do @(negedge clk); while (!cmdReady);
    cmdWrite = wr; cmdAddr = a; cmdWdata = d; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    while (!cmdDone) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_startup_small();
    int n;
    logic [127:0] exp;
    sizeLarge = 1'b0;
    apply_reset();
    n = 0;
    while (!sclLow) begin @(negedge clk); n++; end
    chk("R2 delay lower", 128'(n >= DLY), 1);
    chk("R2 delay upper", 128'(n <= DLY + QC + 4), 1);
    monOn = 1'b1;
    wait_loaded();
    repeat (3) @(negedge clk);
    monOn = 1'b0;
    exp = '0;
    for (int k = 0; k < NW; k++) exp[16*k +: 16] = memWord(2 * k);
    chk("R3 cfgData", cfgData, exp);
    chk("R3 cfgFail", 128'(cfgFail), 0);
    chk("R4 cfg select", 128'(rxLog[0]), 128'(8'hA0));
    chk("R4 cfg addr byte", 128'(rxLog[1]), 0);
    chk("R8 cfg read select", 128'(rxLog[2]), 128'(8'hA1));
    chk("R8 cfg bytes acked then nack", 128'({lastTx, nackSeen}), 128'({32'(2 * NW), 1'b1}));
    chk("R10 min low", 128'(minLow), 128'(2 * QC));
    chk("R10 min high", 128'(minHigh), 128'(2 * QC));
  endtask

  task automatic t_host_read_small();
    host_cmd(1'b0, 15'h02A5, 16'h0);
    chk("R6 rdData", 128'(rdData), 128'({memWord(12'h54C), memWord(12'h54A)}));
    chk("R6 cmdErr", 128'(cmdErr), 0);
    chk("R4 small select", 128'(rxLog[0]), 128'(8'hAA));
    chk("R4 small addr", 128'({lastRxCnt, rxLog[1], rxLog[2]}), 128'({3'd3, 8'h4A, 8'hAB}));
    chk("R8 host nack last", 128'({lastTx, nackSeen}), 128'({32'd4, 1'b1}));
  endtask

  task automatic t_host_write();
    host_cmd(1'b1, 15'h0123, 16'hBEEF);
    chk("R7 low byte", 128'(mem[12'h246]), 128'(8'hEF));
    chk("R7 high byte", 128'(mem[12'h247]), 128'(8'hBE));
    chk("R7 write frame", 128'({lastRxCnt, rxLog[0], rxLog[1], rxLog[2], rxLog[3]}),
        128'({3'd4, 8'hA4, 8'h46, 8'hEF, 8'hBE}));
    chk("R7 cmdErr", 128'(cmdErr), 0);
    host_cmd(1'b0, 15'h0123, 16'h0);
    chk("R7 readback", 128'(rdData[15:0]), 128'(16'hBEEF));
  endtask

  task automatic t_host_read_large();
    sizeLarge = 1'b1;
    host_cmd(1'b0, 15'h02A5, 16'h0);
    chk("R5 rdData", 128'(rdData), 128'({memWord(12'h54C), memWord(12'h54A)}));
    chk("R5 frame", 128'({lastRxCnt, rxLog[0], rxLog[1], rxLog[2], rxLog[3]}),
        128'({3'd4, 8'hA0, 8'h05, 8'h4A, 8'hA1}));
    sizeLarge = 1'b0;
  endtask

  task automatic t_host_nack();
    int s0;
    s0 = stops;
    devAbsent = 1'b1;
    host_cmd(1'b0, 15'h0010, 16'h0);
    chk("R9 cmdErr", 128'(cmdErr), 1);
    chk("R9 stop issued", 128'(stops - s0), 1);
    chk("R9 aborted after select", 128'(lastRxCnt), 1);
    chk("R9 loaded kept", 128'(loaded), 1);
    devAbsent = 1'b0;
  endtask

  task automatic t_cfg_retry();
    logic [127:0] exp;
    devAbsent = 1'b1;
    apply_reset();
    while (!cfgFail) @(negedge clk);
    chk("R9 cfg fail not loaded", 128'(loaded), 0);
    devAbsent = 1'b0;
    wait_loaded();
    exp = '0;
    for (int k = 0; k < NW; k++) exp[16*k +: 16] = memWord(2 * k);
    chk("R9 retry data", cfgData, exp);
    chk("R9 cfgFail cleared", 128'(cfgFail), 0);
  endtask

  task automatic t_collision();
    int s0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    readyEarly = 1'b0;
    s0 = stops;
    cmdWrite = 1'b0; cmdAddr = 15'h0003; cmdValid = 1'b1;
    rstN = 1'b1;
    while (!cmdDone) @(negedge clk);
    cmdValid = 1'b0;
    chk("R11 loaded at done", 128'(loaded), 1);
    repeat (3) @(negedge clk);
    chk("R11 load before command", 128'(stops - s0), 2);
    chk("R11 ready never early", 128'(readyEarly), 0);
    chk("R11 rdData", 128'(rdData), 128'({memWord(8), memWord(6)}));
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 8'(i * 37 + 11);
    for (int i = 0; i < 8; i++) rxLog[i] = '0;
    t_startup_small();
    t_host_read_small();
    t_host_write();
    t_host_read_large();
    t_host_nack();
    t_cfg_retry();
    t_collision();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule